// File: doc/BRIEF.md
# Channel and Interrupt Enable Register Bank

This block holds the control state of a two-channel converter controller: which output channels are switched on and which of four interrupt sources may raise the interrupt line. Software never writes an enable word directly. It writes ones to a "set" register to turn bits on, or to a "clear" register to turn bits off. It then reads the result back through read-only status and mask registers. Bits written as zero keep their state.

The bank also latches the end-of-conversion event. A one-cycle pulse from the converter sets a flag that stays set until software reads the interrupt status register. The other three status bits follow live inputs: a transmit-ready level, a transfer-end level and a buffer-empty level. The interrupt output is the OR of every status bit whose mask bit is set. Writing a one to bit 0 of the control register returns all enables, mask bits and the sticky flag to zero.

Access uses a simple synchronous register bus: word address, write data, a write strobe and a read strobe, with registered read data.

Top module: `chan_irq_regbank`

## Requirements
- R1: A write to address 1 sets each channel enable whose bit in wdata[1:0] is 1. Enables whose bit is 0 keep their state.
- R2: A write to address 2 clears each channel enable whose bit in wdata[1:0] is 1. The other enables keep their state.
- R3: A read of address 3 returns the channel enables in bits [1:0] and zeros above, and ch_en_o shows the same enables. Each bit reflects whichever set or clear write touched it last. All bits are 0 after reset.
- R4: A write to address 4 sets, and a write to address 5 clears, the interrupt mask bits selected by ones in wdata[3:0]. A read of address 6 returns the mask in bits [3:0].
- R5: A read of address 7 returns the status word. Bit 0 is tx_ready_i, bit 1 is the end-of-conversion flag, bit 2 is xfer_end_i and bit 3 is buf_empty_i.
- R6: A cycle with conv_done_i high sets the end-of-conversion flag. A read of address 7 returns the flag's current value and clears it for the following cycle.
- R7: When conv_done_i is high in the same cycle as a read of address 7, the flag stays set afterwards.
- R8: A write to address 0 with wdata[0]=1 clears all channel enables, all mask bits and the end-of-conversion flag, and this takes precedence over a same-cycle conversion pulse. With wdata[0]=0 the write has no effect.
- R9: irq_o is 1 exactly when some status bit (R5) and the mask bit in the same position are both 1. It follows the current state and inputs without a register.
- R10: Reads of addresses 0, 1, 2, 4, 5 and of any address from 8 upward return 0. Writes to addresses 3, 6, 7 and to any address from 8 upward change nothing.
- R11: rdata_o is updated on the clock edge that samples rd_en_i, with the value from before that edge, and holds its value while rd_en_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | ADDR_W (4) | Word address |
| wdata_i | input | DATA_W (32) | Write data |
| rdata_o | output | DATA_W (32) | Registered read data |
| tx_ready_i | input | 1 | Converter can accept new data (level) |
| conv_done_i | input | 1 | One-cycle pulse: a conversion finished |
| xfer_end_i | input | 1 | Transfer-end level |
| buf_empty_i | input | 1 | Buffer-empty level |
| ch_en_o | output | NUM_CH (2) | Channel enables |
| irq_o | output | 1 | Interrupt request |

## Verification
Timing of each result:
- Enable, mask and flag changes take effect on the edge that samples the write strobe or the conversion pulse.
- Read data appears after the edge that samples the read strobe.
- irq_o responds to level inputs in the same cycle.

The bench drives every input on the falling edge. A behavioural model advances on the rising edge, and all three outputs are compared with the model 1 ns after that edge. Directed reads are checked on the falling edge after the strobe's rising edge, which is the first point where the registered read data is valid.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

    localparam int NUM_IRQ = 4;
    localparam int SEL_W   = 3;

    // Interrupt/status bit positions
    localparam int IRQ_READY  = 0;
    localparam int IRQ_EOC    = 1;
    localparam int IRQ_XEND   = 2;
    localparam int IRQ_BEMPTY = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_CTRL     = 3'd0,
        SEL_CH_SET   = 3'd1,
        SEL_CH_CLR   = 3'd2,
        SEL_CH_STAT  = 3'd3,
        SEL_IRQ_SET  = 3'd4,
        SEL_IRQ_CLR  = 3'd5,
        SEL_IRQ_MASK = 3'd6,
        SEL_IRQ_STAT = 3'd7
    } reg_sel_e;

endpackage

// File: rtl/set_clr_bank.sv
module set_clr_bank #(
    parameter int WIDTH = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             sw_rst_i,
    input  logic             set_i,
    input  logic             clr_i,
    input  logic [WIDTH-1:0] bits_i,
    output logic [WIDTH-1:0] q_o
);

    typedef struct packed {
        logic [WIDTH-1:0] en;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sw_rst_i) begin
            st_d.en = '0;
        end else if (set_i) begin
            st_d.en = st_q.en | bits_i;
        end else if (clr_i) begin
            st_d.en = st_q.en & ~bits_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q_o = st_q.en;

    // R1 / R4: selected bits become 1, and bits already on stay on
    a_r1_set_bits_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (set_i && !sw_rst_i) |=> ((q_o & $past(bits_i)) == $past(bits_i)));
    a_r1_set_keeps_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (set_i && !sw_rst_i) |=> ((q_o & $past(q_o)) == $past(q_o)));
    // R2 / R4: selected bits become 0, and bits already off stay off
    a_r2_clr_bits_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i && !set_i && !sw_rst_i) |=> ((q_o & $past(bits_i)) == '0));
    a_r2_clr_keeps_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i && !set_i && !sw_rst_i) |=> ((q_o & ~$past(q_o)) == '0));
    // R8: soft reset empties the bank
    a_r8_soft_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sw_rst_i |=> (q_o == '0));

endmodule

// File: rtl/event_latch.sv
module event_latch (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sw_rst_i,
    input  logic event_i,
    input  logic ack_i,
    output logic flag_o
);

    typedef struct packed {
        logic flag;
    } latch_t;

    latch_t st_d, st_q;

    // Soft reset outranks a new event; a new event outranks the read-clear.
    always_comb begin
        st_d = st_q;
        if (sw_rst_i) begin
            st_d.flag = 1'b0;
        end else if (event_i) begin
            st_d.flag = 1'b1;
        end else if (ack_i) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;

    // R6: an event is captured
    a_r6_event_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (event_i && !sw_rst_i) |=> flag_o);
    // R6: a status read clears the flag when no event arrives with it
    a_r6_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_i && !event_i) |=> !flag_o);
    // R7: a read in the same cycle as an event does not lose it
    a_r7_collision_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_i && event_i && !sw_rst_i) |=> flag_o);
    // R6: with neither event nor read the flag holds
    a_r6_flag_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ack_i && !event_i && !sw_rst_i) |=> (flag_o == $past(flag_o)));
    // R8: soft reset clears the flag
    a_r8_flag_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sw_rst_i |=> !flag_o);

endmodule

// File: rtl/chan_irq_regbank.sv
module chan_irq_regbank #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int NUM_CH = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic              tx_ready_i,
    input  logic              conv_done_i,
    input  logic              xfer_end_i,
    input  logic              buf_empty_i,
    output logic [NUM_CH-1:0] ch_en_o,
    output logic              irq_o
);

    import regbank_pkg::*;

    localparam int IRQ_N = regbank_pkg::NUM_IRQ;
    localparam int SW    = regbank_pkg::SEL_W;

    // ---------------- address decode ----------------
    logic     hit;
    reg_sel_e sel;

    generate
        if (ADDR_W > SW) begin : g_hi_decode
            assign hit = (addr_i[ADDR_W-1:SW] == '0);
        end else begin : g_no_hi
            assign hit = 1'b1;
        end
    endgenerate

    assign sel = reg_sel_e'(addr_i[SW-1:0]);

    logic wr_hit, rd_hit;
    logic sw_rst, ch_set, ch_clr, irq_set, irq_clr, stat_rd;

    assign wr_hit  = wr_en_i && hit;
    assign rd_hit  = rd_en_i && hit;
    assign sw_rst  = wr_hit && (sel == SEL_CTRL) && wdata_i[0];
    assign ch_set  = wr_hit && (sel == SEL_CH_SET);
    assign ch_clr  = wr_hit && (sel == SEL_CH_CLR);
    assign irq_set = wr_hit && (sel == SEL_IRQ_SET);
    assign irq_clr = wr_hit && (sel == SEL_IRQ_CLR);
    assign stat_rd = rd_hit && (sel == SEL_IRQ_STAT);

    logic unused_wdata;
    assign unused_wdata = ^wdata_i[DATA_W-1:IRQ_N];

    // ---------------- state banks ----------------
    logic [NUM_CH-1:0] ch_en;
    logic [IRQ_N-1:0]  irq_mask;
    logic              eoc_flag;

    set_clr_bank #(.WIDTH(NUM_CH)) i_ch_bank (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .sw_rst_i (sw_rst),
        .set_i    (ch_set),
        .clr_i    (ch_clr),
        .bits_i   (wdata_i[NUM_CH-1:0]),
        .q_o      (ch_en)
    );

    set_clr_bank #(.WIDTH(IRQ_N)) i_mask_bank (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .sw_rst_i (sw_rst),
        .set_i    (irq_set),
        .clr_i    (irq_clr),
        .bits_i   (wdata_i[IRQ_N-1:0]),
        .q_o      (irq_mask)
    );

    event_latch i_eoc_latch (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .sw_rst_i (sw_rst),
        .event_i  (conv_done_i),
        .ack_i    (stat_rd),
        .flag_o   (eoc_flag)
    );

    // ---------------- status and interrupt ----------------
    logic [IRQ_N-1:0] irq_stat;

    always_comb begin
        irq_stat             = '0;
        irq_stat[IRQ_READY]  = tx_ready_i;
        irq_stat[IRQ_EOC]    = eoc_flag;
        irq_stat[IRQ_XEND]   = xfer_end_i;
        irq_stat[IRQ_BEMPTY] = buf_empty_i;
    end

    assign irq_o   = |(irq_stat & irq_mask);
    assign ch_en_o = ch_en;

    // ---------------- read port ----------------
    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rd_t;

    rd_t rd_d, rd_q;

    always_comb begin
        rd_d = rd_q;
        if (rd_en_i) begin
            rd_d.rdata = '0;
            if (hit) begin
                case (sel)
                    SEL_CH_STAT:  rd_d.rdata[NUM_CH-1:0] = ch_en;
                    SEL_IRQ_MASK: rd_d.rdata[IRQ_N-1:0]  = irq_mask;
                    SEL_IRQ_STAT: rd_d.rdata[IRQ_N-1:0]  = irq_stat;
                    default:      rd_d.rdata             = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rdata_o = rd_q.rdata;

    // R10: write-only and unmapped addresses read as zero
    a_r10_wo_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_i && (!hit || sel inside {SEL_CTRL, SEL_CH_SET, SEL_CH_CLR,
                                         SEL_IRQ_SET, SEL_IRQ_CLR}))
        |=> (rdata_o == '0));
    // R11: read data holds without a read strobe
    a_r11_rdata_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_en_i |=> $stable(rdata_o));
    // R10: writes that decode to no writable register leave the enables alone
    a_r10_ro_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ch_set && !ch_clr && !sw_rst) |=> $stable(ch_en_o));

endmodule

// File: tb/test_chan_irq_regbank.sv
`timescale 1ns/1ps
module test_chan_irq_regbank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        tx_ready = 1'b0, conv_done = 1'b0, xfer_end = 1'b0, buf_empty = 1'b0;
    logic [1:0]  ch_en;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    chan_irq_regbank i_chan_irq_regbank (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .wr_en_i     (wr_en),
        .rd_en_i     (rd_en),
        .addr_i      (addr),
        .wdata_i     (wdata),
        .rdata_o     (rdata),
        .tx_ready_i  (tx_ready),
        .conv_done_i (conv_done),
        .xfer_end_i  (xfer_end),
        .buf_empty_i (buf_empty),
        .ch_en_o     (ch_en),
        .irq_o       (irq)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [1:0]  m_ch = '0;
    logic [3:0]  m_mask = '0;
    logic        m_eoc = 1'b0;
    logic [31:0] m_rdata = '0;

    always @(posedge clk) begin
        logic [1:0] o_ch;
        logic [3:0] o_mask;
        logic       o_eoc;
        logic       stat_read;
        o_ch   = m_ch;
        o_mask = m_mask;
        o_eoc  = m_eoc;
        stat_read = rd_en && (addr == 4'd7);
        if (!rst_n) begin
            m_ch = '0; m_mask = '0; m_eoc = 1'b0; m_rdata = '0;
        end else begin
            if (rd_en) begin
                case (addr)
                    4'd3:    m_rdata = {30'd0, o_ch};
                    4'd6:    m_rdata = {28'd0, o_mask};
                    4'd7:    m_rdata = {28'd0, buf_empty, xfer_end, o_eoc, tx_ready};
                    default: m_rdata = '0;
                endcase
            end
            if (wr_en && addr == 4'd0 && wdata[0]) begin
                m_ch = '0; m_mask = '0; m_eoc = 1'b0;
            end else begin
                if (conv_done)      m_eoc = 1'b1;
                else if (stat_read) m_eoc = 1'b0;
                if (wr_en) begin
                    case (addr)
                        4'd1: m_ch   = o_ch | wdata[1:0];
                        4'd2: m_ch   = o_ch & ~wdata[1:0];
                        4'd4: m_mask = o_mask | wdata[3:0];
                        4'd5: m_mask = o_mask & ~wdata[3:0];
                        default: ;
                    endcase
                end
            end
        end
        #1;
        if (rst_n) begin
            check({30'd0, ch_en}, {30'd0, m_ch}, "R3 model ch_en_o");
            check({31'd0, irq},
                  {31'd0, |({buf_empty, xfer_end, m_eoc, tx_ready} & m_mask)}, "R9 model irq_o");
            check(rdata, m_rdata, "R11 model rdata_o");
        end
    end

    // ---------------- bus tasks ----------------
    task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic bus_rd(input logic [3:0] a, input logic [31:0] exp, input string tag,
                          input bit conv = 1'b0);
        @(negedge clk);
        rd_en = 1'b1; addr = a; conv_done = conv;
        @(negedge clk);
        rd_en = 1'b0; conv_done = 1'b0;
        check(rdata, exp, tag);
    endtask

    task automatic pulse_conv();
        @(negedge clk);
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
    endtask

    // ---------------- directed sequence ----------------
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check({30'd0, ch_en}, 32'd0, "R3 reset enables");
        check({31'd0, irq}, 32'd0, "R9 reset irq");
        check(rdata, 32'd0, "R11 reset rdata");

        // channel set/clear
        bus_wr(4'd1, 32'h1);
        check({30'd0, ch_en}, 32'h1, "R1 set ch0");
        bus_wr(4'd1, 32'h0);
        check({30'd0, ch_en}, 32'h1, "R1 zero write no effect");
        bus_wr(4'd1, 32'h2);
        bus_rd(4'd3, 32'h3, "R3 status both enabled");
        bus_wr(4'd2, 32'h1);
        check({30'd0, ch_en}, 32'h2, "R2 clear ch0 only");
        bus_rd(4'd3, 32'h2, "R3 status after clear");
        bus_wr(4'd1, 32'h1);
        bus_wr(4'd2, 32'h3);
        bus_rd(4'd3, 32'h0, "R2 clear both, last write wins");
        bus_wr(4'd1, 32'h3);

        // interrupt mask
        bus_wr(4'd4, 32'hA);
        bus_rd(4'd6, 32'hA, "R4 mask after set");
        bus_wr(4'd5, 32'h8);
        bus_rd(4'd6, 32'h2, "R4 mask after clear");

        // end of conversion flag
        tx_ready = 1'b1;
        pulse_conv();
        check({31'd0, irq}, 32'h1, "R9 irq from eoc");
        bus_rd(4'd7, 32'h3, "R6 eoc set, R5 ready bit");
        bus_rd(4'd7, 32'h1, "R6 eoc cleared by read");
        check({31'd0, irq}, 32'h0, "R9 irq drops after read");

        // collision
        pulse_conv();
        bus_rd(4'd7, 32'h3, "R7 read with new conversion", 1'b1);
        bus_rd(4'd7, 32'h3, "R7 flag kept after collision");
        bus_rd(4'd7, 32'h1, "R6 flag cleared afterwards");

        // level sources
        xfer_end = 1'b1; buf_empty = 1'b1;
        bus_rd(4'd7, 32'hD, "R5 level status bits");
        bus_wr(4'd4, 32'h8);
        check({31'd0, irq}, 32'h1, "R9 irq from buffer empty");
        @(negedge clk) buf_empty = 1'b0;
        #1 check({31'd0, irq}, 32'h0, "R9 irq follows level");
        xfer_end = 1'b0;

        // write-only and unmapped addresses
        bus_rd(4'd0, 32'h0, "R10 read ctrl");
        bus_rd(4'd1, 32'h0, "R10 read ch set");
        bus_rd(4'd2, 32'h0, "R10 read ch clr");
        bus_rd(4'd4, 32'h0, "R10 read irq set");
        bus_rd(4'd5, 32'h0, "R10 read irq clr");
        bus_rd(4'd9, 32'h0, "R10 read unmapped");
        bus_wr(4'd3, 32'h0);
        bus_wr(4'd6, 32'h0);
        bus_wr(4'd10, 32'hF);
        bus_wr(4'd9, 32'hF);
        bus_rd(4'd3, 32'h3, "R10 ro/unmapped writes keep enables");
        bus_rd(4'd6, 32'hA, "R10 ro/unmapped writes keep mask");

        // read data holds
        repeat (3) @(negedge clk);
        check(rdata, 32'hA, "R11 rdata holds while idle");

        // soft reset
        pulse_conv();
        bus_wr(4'd0, 32'h0);
        bus_rd(4'd3, 32'h3, "R8 ctrl write with bit0 clear");
        @(negedge clk);
        wr_en = 1'b1; addr = 4'd0; wdata = 32'h1; conv_done = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0; conv_done = 1'b0;
        check({30'd0, ch_en}, 32'h0, "R8 soft reset enables");
        bus_rd(4'd6, 32'h0, "R8 soft reset mask");
        bus_rd(4'd7, 32'h1, "R8 soft reset eoc beats conversion");

        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule